// File: doc/BRIEF.md
# Compact 32-bit Register-Machine Core

This block is a small in-order processor. It reads 32-bit instruction words from a synchronous program memory and executes a fixed, irregular instruction set. It has sixteen 32-bit general registers, a 24-bit program counter and an eight-entry hardware return-address stack. The instruction set covers no-op, return, immediate half-word loads, register add, bitwise AND and copy, a register-addressed output write, absolute jump and subroutine call.

Every instruction takes two clock cycles. In the fetch cycle the program counter drives the memory address, and the memory registers the word. In the execute cycle the core decodes that word and updates the registers, the stack and the program counter. A write to the output port leaves the core as a registered single-cycle strobe, with its address and data taken from two source registers. The core has no flags and no data loads, and it has no conditional branches.

Top module: `rmc_core`

## Requirements
- R1: A synchronous reset clears the program counter, all sixteen registers and the return-stack pointer. It drops the output strobe and puts the core in its fetch phase.
- R2: Every instruction uses one fetch cycle and then one execute cycle. The instruction address stays stable through the execute cycle. The strobe of an output write made by the n-th instruction after reset is high in cycle 2n, counting the first cycle after reset release as cycle 0.
- R3: The word 0x00000000 only advances the program counter by one. Any word that matches none of the encodings below does the same and changes no register and no output.
- R4: Immediate load: bits 31:28 = 0101, target in 27:24, immediate in 15:0, bits 22:16 zero. Bit 23 = 1 writes the upper 16 bits and bit 23 = 0 writes the lower 16 bits. The other half of the register is kept.
- R5: Register arithmetic: bits 31:28 = 0001, destination 27:24, first source 23:20, second source 19:16. A function field of bits 15:0 = 0x0E00 stores the sum modulo 2^32, and 0x4C00 stores the bitwise AND.
- R6: Register copy: bits 31:28 = 0001, destination 27:24, source 23:20, bits 19:16 zero and bits 15:0 = 0x2E00.
- R7: Output write: bits 31:24 = 0x20 and bits 15:0 zero. It drives the value of the register in 23:20 as the address and the value of the register in 19:16 as the data, and raises the strobe for exactly one cycle.
- R8: Bits 31:24 = 0xEF loads the program counter with bits 23:0.
- R9: Bits 31:24 = 0xE0 pushes the call's own address plus one onto the return stack and loads the program counter with bits 23:0. The stack holds eight entries, and its pointer wraps, so a ninth push overwrites the oldest entry.
- R10: The word 0x00000001 pops the return stack into the program counter. If the stack pointer is zero, the program counter becomes 0 and the pointer stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 24 | Program memory word address (the program counter) |
| imem_data | input | 32 | Instruction word, valid one cycle after its address |
| out_addr | output | 32 | Output write address |
| out_data | output | 32 | Output write data |
| out_we | output | 1 | Output write strobe, one cycle per write |

## Verification
The assertions take for granted that the program memory has exactly one cycle of read latency, so the word on imem_data in the execute cycle belongs to the address held in the fetch cycle. They also assume reset is held for at least one rising edge. The bench keeps to this with a synchronous memory model that registers the word at every edge, and it changes reset only between edges while holding it for several cycles. Each program ends in a jump to itself, so the instruction stream never runs into undefined memory.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int XLEN   = 32;
    localparam int PC_W   = 24;
    localparam int NREG   = 16;
    localparam int RIDX_W = $clog2(NREG);
    localparam int IMM_W  = 16;

    localparam logic [3:0]  MAJ_LOAD = 4'h5;
    localparam logic [3:0]  MAJ_ALU  = 4'h1;
    localparam logic [7:0]  MAJ_OUT  = 8'h20;
    localparam logic [7:0]  MAJ_JMP  = 8'hEF;
    localparam logic [7:0]  MAJ_CALL = 8'hE0;
    localparam logic [15:0] FN_ADD   = 16'h0E00;
    localparam logic [15:0] FN_AND   = 16'h4C00;
    localparam logic [15:0] FN_MOV   = 16'h2E00;
    localparam logic [31:0] W_NOP    = 32'h0000_0000;
    localparam logic [31:0] W_RET    = 32'h0000_0001;

    typedef enum logic [3:0] {
        OP_NOP, OP_RET, OP_LDLO, OP_LDHI, OP_ADD,
        OP_AND, OP_MOV, OP_OUT, OP_JMP, OP_CALL
    } op_e;

    typedef enum logic {PH_FETCH, PH_EXEC} phase_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs1;
        logic [RIDX_W-1:0] rs2;
        logic [IMM_W-1:0]  imm;
        logic [PC_W-1:0]   target;
    } dec_t;

endpackage

// File: rtl/rmc_decode.sv
module rmc_decode
    import rmc_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [3:0]  nib_hi;
    logic [7:0]  byte_hi;
    logic [15:0] fn;

    always_comb begin
        nib_hi     = instr[31:28];
        byte_hi    = instr[31:24];
        fn         = instr[15:0];
        dec.rd     = instr[27:24];
        dec.rs1    = instr[23:20];
        dec.rs2    = instr[19:16];
        dec.imm    = instr[15:0];
        dec.target = instr[23:0];
        dec.op     = OP_NOP;
        if (instr == W_RET) begin
            dec.op = OP_RET;
        end else if (nib_hi == MAJ_LOAD && instr[22:16] == 7'd0) begin
            dec.op = instr[23] ? OP_LDHI : OP_LDLO;
        end else if (nib_hi == MAJ_ALU) begin
            if (fn == FN_ADD)
                dec.op = OP_ADD;
            else if (fn == FN_AND)
                dec.op = OP_AND;
            else if (fn == FN_MOV && instr[19:16] == 4'd0)
                dec.op = OP_MOV;
        end else if (byte_hi == MAJ_OUT && fn == 16'd0) begin
            dec.op = OP_OUT;
        end else if (byte_hi == MAJ_JMP) begin
            dec.op = OP_JMP;
        end else if (byte_hi == MAJ_CALL) begin
            dec.op = OP_CALL;
        end
    end

endmodule

// File: rtl/rmc_regs.sv
module rmc_regs #(
    parameter int NREG = 16,
    parameter int XLEN = 32,
    localparam int AW   = $clog2(NREG),
    localparam int HALF = XLEN / 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we_lo,
    input  logic            we_hi,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2
);

    logic [XLEN-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] nxt_d;
        always_comb begin
            nxt_d = regs_q[g];
            if (wa == AW'(g)) begin
                if (we_lo) nxt_d[HALF-1:0]    = wd[HALF-1:0];
                if (we_hi) nxt_d[XLEN-1:HALF] = wd[XLEN-1:HALF];
            end
        end
        always_ff @(posedge clk) begin
            if (rst) regs_q[g] <= '0;
            else     regs_q[g] <= nxt_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

endmodule

// File: rtl/rmc_rstack.sv
module rmc_rstack #(
    parameter int DEPTH = 8,
    parameter int AW    = 24,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_addr,
    output logic [AW-1:0] top_addr
);

    logic [AW-1:0] ent_q [DEPTH];
    logic [AW-1:0] ent_d [DEPTH];
    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        ent_d = ent_q;
        ptr_d = ptr_q;
        if (push) begin
            ent_d[ptr_q] = push_addr;
            ptr_d        = ptr_q + PW'(1);
        end else if (pop && ptr_q != '0) begin
            ptr_d = ptr_q - PW'(1);
        end
    end

    assign top_addr = (ptr_q == '0) ? '0 : ent_q[ptr_q - PW'(1)];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            ptr_q <= ptr_d;
            ent_q <= ent_d;
        end
    end

endmodule

// File: rtl/rmc_core.sv
module rmc_core
    import rmc_pkg::*;
#(
    parameter int STACK_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [31:0]     imem_data,
    output logic [XLEN-1:0] out_addr,
    output logic [XLEN-1:0] out_data,
    output logic            out_we
);

    typedef struct packed {
        phase_e          phase;
        logic [PC_W-1:0] pc;
        logic            wr_en;
        logic [XLEN-1:0] wr_addr;
        logic [XLEN-1:0] wr_data;
    } core_state_t;

    core_state_t state_d, state_q;
    dec_t        dec;

    logic              rf_we_lo, rf_we_hi;
    logic [XLEN-1:0]   rf_wd, rf_rd1, rf_rd2;
    logic              stk_push, stk_pop;
    logic [PC_W-1:0]   stk_top, pc_next_seq;

    rmc_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    rmc_regs #(.NREG(NREG), .XLEN(XLEN)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we_lo (rf_we_lo),
        .we_hi (rf_we_hi),
        .wa    (dec.rd),
        .wd    (rf_wd),
        .ra1   (dec.rs1),
        .ra2   (dec.rs2),
        .rd1   (rf_rd1),
        .rd2   (rf_rd2)
    );

    rmc_rstack #(.DEPTH(STACK_DEPTH), .AW(PC_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_addr (pc_next_seq),
        .top_addr  (stk_top)
    );

    assign pc_next_seq = state_q.pc + PC_W'(1);

    always_comb begin
        state_d       = state_q;
        state_d.wr_en = 1'b0;
        rf_we_lo      = 1'b0;
        rf_we_hi      = 1'b0;
        rf_wd         = '0;
        stk_push      = 1'b0;
        stk_pop       = 1'b0;
        if (state_q.phase == PH_FETCH) begin
            state_d.phase = PH_EXEC;
        end else begin
            state_d.phase = PH_FETCH;
            state_d.pc    = pc_next_seq;
            unique case (dec.op)
                OP_LDLO: begin
                    rf_we_lo = 1'b1;
                    rf_wd    = {2{dec.imm}};
                end
                OP_LDHI: begin
                    rf_we_hi = 1'b1;
                    rf_wd    = {2{dec.imm}};
                end
                OP_ADD: begin
                    rf_we_lo = 1'b1;
                    rf_we_hi = 1'b1;
                    rf_wd    = rf_rd1 + rf_rd2;
                end
                OP_AND: begin
                    rf_we_lo = 1'b1;
                    rf_we_hi = 1'b1;
                    rf_wd    = rf_rd1 & rf_rd2;
                end
                OP_MOV: begin
                    rf_we_lo = 1'b1;
                    rf_we_hi = 1'b1;
                    rf_wd    = rf_rd1;
                end
                OP_OUT: begin
                    state_d.wr_en   = 1'b1;
                    state_d.wr_addr = rf_rd1;
                    state_d.wr_data = rf_rd2;
                end
                OP_JMP: begin
                    state_d.pc = dec.target;
                end
                OP_CALL: begin
                    stk_push   = 1'b1;
                    state_d.pc = dec.target;
                end
                OP_RET: begin
                    stk_pop    = 1'b1;
                    state_d.pc = stk_top;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.phase   <= PH_FETCH;
            state_q.pc      <= '0;
            state_q.wr_en   <= 1'b0;
            state_q.wr_addr <= '0;
            state_q.wr_data <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign imem_addr = state_q.pc;
    assign out_addr  = state_q.wr_addr;
    assign out_data  = state_q.wr_data;
    assign out_we    = state_q.wr_en;

endmodule

// File: rtl/rmc_core_chk.sv
module rmc_core_chk
    import rmc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] imem_addr,
    input logic [31:0]     imem_data,
    input logic            out_we,
    input phase_e          phase
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !out_we && phase == PH_FETCH));

    assert_fetch_then_exec_R2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> phase == PH_EXEC);

    assert_exec_then_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_EXEC |=> phase == PH_FETCH);

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> $stable(imem_addr));

    assert_nop_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && imem_data == 32'd0)
        |=> imem_addr == PC_W'($past(imem_addr) + PC_W'(1)));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
        out_we |=> !out_we);

    assert_strobe_source_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && imem_data[31:24] != 8'h20) |=> !out_we);

    assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && imem_data[31:24] == 8'hEF)
        |=> imem_addr == $past(imem_data[23:0]));

    assert_call_target_R9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && imem_data[31:24] == 8'hE0)
        |=> imem_addr == $past(imem_data[23:0]));

endmodule

bind rmc_core rmc_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .out_we    (out_we),
    .phase     (state_q.phase)
);

// File: tb/test_rmc_core.sv
module test_rmc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] out_addr, out_data;
    logic        out_we;

    logic [31:0] mem [512];
    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int log_n = 0;
    logic [31:0] log_a [16];
    logic [31:0] log_d [16];
    int          log_c [16];

    always #10 clk = ~clk;

    rmc_core i_rmc_core (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .out_addr  (out_addr),
        .out_data  (out_data),
        .out_we    (out_we)
    );

    always @(posedge clk) imem_data <= mem[imem_addr[8:0]];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (rst) log_n = 0;
        else if (out_we && log_n < 16) begin
            log_a[log_n] = out_addr;
            log_d[log_n] = out_data;
            log_c[log_n] = cyc;
            log_n = log_n + 1;
        end
    end

    function automatic logic [31:0] e_ldl(input logic [3:0] r, input logic [15:0] v);
        return {4'h5, r, 8'h00, v};
    endfunction
    function automatic logic [31:0] e_ldh(input logic [3:0] r, input logic [15:0] v);
        return {4'h5, r, 8'h80, v};
    endfunction
    function automatic logic [31:0] e_alu(input logic [3:0] d, input logic [3:0] a,
                                          input logic [3:0] b, input logic [15:0] fn);
        return {4'h1, d, a, b, fn};
    endfunction
    function automatic logic [31:0] e_out(input logic [3:0] a, input logic [3:0] b);
        return {8'h20, a, b, 16'h0000};
    endfunction
    function automatic logic [31:0] e_jmp(input logic [23:0] t);
        return {8'hEF, t};
    endfunction
    function automatic logic [31:0] e_call(input logic [23:0] t);
        return {8'hE0, t};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_wr(input int i, input string req, input logic [31:0] ea,
                          input logic [31:0] ed);
        chk(log_n > i, req, 32'(log_n), 32'(i + 1));
        if (log_n > i) begin
            chk(log_a[i] == ea, req, log_a[i], ea);
            chk(log_d[i] == ed, req, log_d[i], ed);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 32'd0;
    endtask

    task automatic run_prog(input int n);
        @(posedge clk); #5 rst = 1'b1;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        repeat (n) @(posedge clk);
        #5;
    endtask

    // {a, b, a+b, a&b}
    localparam logic [127:0] VECS [5] = '{
        {32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
        {32'h1234_5678, 32'h0F0F_0F0F, 32'h2143_6587, 32'h0204_0608},
        {32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
        {32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    initial begin
        #3_000_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (2) @(posedge clk);
        #10;
        // R1: state while reset is held
        chk(imem_addr == 24'd0, "R1 pc in reset", 32'(imem_addr), 32'd0);
        chk(out_we == 1'b0, "R1 strobe in reset", 32'(out_we), 32'd0);

        // Vector table: R4 R5 R6 R7 R2
        foreach (VECS[k]) begin
            logic [31:0] a, b, s, m;
            {a, b, s, m} = VECS[k];
            clear_mem();
            mem[0]  = e_ldl(4'd1, a[15:0]);
            mem[1]  = e_ldh(4'd1, a[31:16]);
            mem[2]  = e_ldl(4'd2, b[15:0]);
            mem[3]  = e_ldh(4'd2, b[31:16]);
            mem[4]  = e_alu(4'd3, 4'd1, 4'd2, 16'h0E00);
            mem[5]  = e_alu(4'd4, 4'd1, 4'd2, 16'h4C00);
            mem[6]  = e_alu(4'd5, 4'd3, 4'd0, 16'h2E00);
            mem[7]  = e_out(4'd1, 4'd3);
            mem[8]  = e_out(4'd2, 4'd4);
            mem[9]  = e_out(4'd5, 4'd5);
            mem[10] = e_jmp(24'd10);
            run_prog(40);
            chk_wr(0, "R5 add", a, s);
            chk_wr(1, "R5 and", b, m);
            chk_wr(2, "R6 copy", s, s);
            chk(log_n == 3, "R7 write count", 32'(log_n), 32'd3);
            chk(log_c[0] == 16, "R2 write cycle", 32'(log_c[0]), 32'd16);
        end

        // R1: reset after a run clears registers; first write in cycle 2 (R2)
        clear_mem();
        mem[0] = e_out(4'd1, 4'd3);
        mem[1] = e_jmp(24'd1);
        run_prog(20);
        chk_wr(0, "R1 regs cleared", 32'd0, 32'd0);
        chk(log_c[0] == 2, "R2 first write cycle", 32'(log_c[0]), 32'd2);
        chk(log_n == 1, "R8 jump to self", 32'(log_n), 32'd1);

        // R4: half loads keep the other half; bits 22:16 nonzero -> no-op
        clear_mem();
        mem[0] = e_ldh(4'd6, 16'hABCD);
        mem[1] = e_ldl(4'd6, 16'h1234);
        mem[2] = e_out(4'd6, 4'd6);
        mem[3] = e_ldl(4'd6, 16'hFFFF);
        mem[4] = e_out(4'd0, 4'd6);
        mem[5] = 32'h5681_1111;
        mem[6] = e_out(4'd0, 4'd6);
        mem[7] = e_jmp(24'd7);
        run_prog(40);
        chk_wr(0, "R4 both halves", 32'hABCD_1234, 32'hABCD_1234);
        chk_wr(1, "R4 low keeps high", 32'd0, 32'hABCD_FFFF);
        chk_wr(2, "R4 reserved bits no-op", 32'd0, 32'hABCD_FFFF);

        // R3: unlisted encodings are no-ops
        clear_mem();
        mem[0] = e_ldl(4'd1, 16'h0005);
        mem[1] = 32'hFFFF_FFFF;
        mem[2] = 32'h1111_0E01;
        mem[3] = 32'h2011_0001;
        mem[4] = 32'h1211_2E00;
        mem[5] = 32'hE100_0005;
        mem[6] = 32'h1000_0000;
        mem[7] = e_out(4'd1, 4'd2);
        mem[8] = e_jmp(24'd8);
        run_prog(40);
        chk_wr(0, "R3 unknown words ignored", 32'd5, 32'd0);
        chk(log_n == 1, "R3 no stray write", 32'(log_n), 32'd1);
        chk(log_c[0] == 16, "R3 pc advanced by one each", 32'(log_c[0]), 32'd16);

        // R9 R10: nested call and return
        clear_mem();
        mem[0]  = e_call(24'd10);
        mem[1]  = e_out(4'd1, 4'd2);
        mem[2]  = e_jmp(24'd2);
        mem[10] = e_ldl(4'd1, 16'h0077);
        mem[11] = e_call(24'd20);
        mem[12] = 32'h0000_0001;
        mem[20] = e_ldl(4'd2, 16'h0055);
        mem[21] = 32'h0000_0001;
        run_prog(40);
        chk_wr(0, "R9 nested call return", 32'h77, 32'h55);
        chk(log_c[0] == 14, "R10 return path cycle", 32'(log_c[0]), 32'd14);
        chk(log_n == 1, "R10 single write", 32'(log_n), 32'd1);

        // R10: return with empty stack goes to 0 and stays at 0
        clear_mem();
        mem[0] = e_alu(4'd1, 4'd1, 4'd2, 16'h0E00);
        mem[1] = e_out(4'd1, 4'd1);
        mem[2] = e_ldl(4'd2, 16'h0001);
        mem[3] = 32'h0000_0001;
        run_prog(30);
        chk_wr(0, "R10 underflow pass0", 32'd0, 32'd0);
        chk_wr(1, "R10 underflow pass1", 32'd1, 32'd1);
        chk_wr(2, "R10 underflow pass2", 32'd2, 32'd2);
        chk(log_c[1] == 12, "R10 underflow cycle", 32'(log_c[1]), 32'd12);

        // R9: ninth push wraps and overwrites the oldest entry
        clear_mem();
        for (int k = 0; k < 9; k++) mem[4*k] = e_call(24'(4*k + 4));
        for (int k = 0; k < 8; k++) mem[4*k + 1] = e_out(4'd0, 4'd0);
        mem[36] = 32'h0000_0001;
        mem[33] = e_out(4'd3, 4'd3);
        mem[34] = e_jmp(24'd34);
        run_prog(40);
        chk(log_n == 1, "R9 stack wrap count", 32'(log_n), 32'd1);
        chk(log_c[0] == 22, "R9 stack wrap cycle", 32'(log_c[0]), 32'd22);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule